// File: doc/BRIEF.md
# Trace Capture Buffer Controller

This block stores bus-cycle trace records (address, data and cycle type) in a ring of storage that is overwritten oldest-first, so it always holds the most recent activity. A run-start pulse arms it. After that, each valid cycle is offered for capture. In unfiltered mode every valid cycle is kept. In windowed mode a cycle is kept only when its address falls inside a programmed address range.

A trigger strobe marks the point of interest. A position setting chooses how much history is kept around that point. The capture can begin at the trigger, surround it with half the buffer on each side, or end at the trigger. Once the chosen number of records after the trigger has been stored, the buffer freezes. It stays frozen until software re-arms it. A host reads the frozen contents through a combinational read port and uses the write pointer and wrap flag to find the valid range.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, frozen, wrapped and the write pointer are all 0, and records are not stored while the controller is idle (before a run-start pulse).
- R2: While armed with window mode off, every valid record is stored at the write-pointer slot, and the pointer then advances by one, modulo DEPTH.
- R3: With window mode on, a record is stored only if win_lo <= address <= win_hi, with both bounds inclusive. A window with win_lo > win_hi matches no record.
- R4: Storage is circular: a write at slot DEPTH-1 sets the wrap flag and moves the pointer back to slot 0, so new records overwrite the oldest. The wrap flag then stays set until re-arm.
- R5: Position code 0 (start): no record is stored before the trigger. The trigger-cycle record and the qualifying records that follow are stored until DEPTH records have been stored, and then the buffer freezes.
- R6: Position code 1 (middle): records are stored before the trigger. From the trigger cycle on, DEPTH/2 more qualifying records are stored, and then the buffer freezes.
- R7: Position codes 2 and 3 (end): records are stored until the trigger. The buffer freezes at the trigger edge, and the trigger-cycle record is not stored.
- R8: While frozen, records and triggers are ignored, and the write pointer and wrap flag hold. A trigger that arrives while capture after a trigger is still in progress is also ignored.
- R9: A re-arm pulse takes priority over all other inputs. It clears the pointer, the wrap flag and the frozen state, and it arms a new capture. The record in the re-arm cycle is not stored.
- R10: A run-start pulse arms the controller only from idle. In any other state it has no effect.
- R11: rd_data returns, in the same cycle, the stored record at slot rd_addr, packed as {type, data, address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | A bus-cycle record is present this cycle |
| rec_addr | input | AW | Address of the bus cycle |
| rec_data | input | DW | Data of the bus cycle |
| rec_type | input | TW | Bus cycle type code |
| trig | input | 1 | Trigger strobe |
| run_start | input | 1 | Program start pulse; arms the controller from idle |
| rearm | input | 1 | Clears the buffer state and arms a new capture |
| win_en | input | 1 | 1 selects windowed (area) capture |
| win_lo | input | AW | Lower window bound, inclusive |
| win_hi | input | AW | Upper window bound, inclusive |
| trig_pos | input | 2 | 0 start, 1 middle, 2 or 3 end |
| rd_addr | input | $clog2(DEPTH) | Read slot |
| rd_data | output | TW+DW+AW | Stored record at rd_addr |
| frozen | output | 1 | Capture has stopped |
| wr_ptr | output | $clog2(DEPTH) | Next slot to be written |
| wrapped | output | 1 | Pointer has passed the last slot at least once |

## Verification
The hardest case is the interaction at the edges of the capture after a trigger. The countdown must stop exactly on the last qualifying record even when invalid cycles and cycles outside the window fall inside it. At the same time, triggers and re-arm pulses that arrive mid-countdown or at the freeze edge must not disturb it. The directed phases bring the buffer to these edges in each position mode, including a window that is narrow and one that is inverted. A long random phase then mixes sparse valid cycles, frequent triggers and occasional re-arms while configuration changes. Every cycle is compared against a behavioural model, and the stored contents are read back periodically.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_POST   = 2'd2,
        ST_FROZEN = 2'd3
    } tcb_state_e;

    localparam logic [1:0] POS_START = 2'd0;
    localparam logic [1:0] POS_MID   = 2'd1;
endpackage

// File: rtl/tcb_window.sv
module tcb_window #(
    parameter int AW = 16
) (
    input  logic          valid_i,
    input  logic          win_en_i,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic [AW-1:0] addr_i,
    output logic          keep_o
);
    logic in_range;

    always_comb begin
        in_range = (addr_i >= lo_i) && (addr_i <= hi_i);
        keep_o   = valid_i && (!win_en_i || in_range);
    end

    // R3: an inverted window never qualifies a record
    always_comb begin
        if (win_en_i && (lo_i > hi_i)) begin
            p_empty_window_r3: assert (!keep_o);
        end
    end
endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
    parameter int DEPTH = 16,
    parameter int RW    = 36,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [PW-1:0] waddr_i,
    input  logic [RW-1:0] wdata_i,
    input  logic [PW-1:0] raddr_i,
    output logic [RW-1:0] rdata_o
);
    logic [RW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = cells_q[raddr_i];
    end
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
    import tcb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep_i,
    input  logic          trig_i,
    input  logic          run_start_i,
    input  logic          rearm_i,
    input  logic [1:0]    pos_i,
    output logic          we_o,
    output logic [PW-1:0] ptr_o,
    output logic          wrapped_o,
    output logic          frozen_o
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

    typedef struct packed {
        tcb_state_e    st;
        logic [PW-1:0] ptr;
        logic          wrapped;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t         s_d, s_q;
    logic [CW-1:0] load_d;
    logic [CW-1:0] left_d;
    logic [CW-1:0] rem_d;
    logic          we_d;

    always_comb begin
        unique case (pos_i)
            POS_START: load_d = CW'(DEPTH);
            POS_MID:   load_d = CW'(DEPTH / 2);
            default:   load_d = '0;
        endcase
    end

    always_comb begin
        s_d    = s_q;
        we_d   = 1'b0;
        left_d = '0;
        rem_d  = '0;
        if (rearm_i) begin
            s_d.st      = ST_ARMED;
            s_d.ptr     = '0;
            s_d.wrapped = 1'b0;
            s_d.cnt     = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (run_start_i) begin
                        s_d.st      = ST_ARMED;
                        s_d.ptr     = '0;
                        s_d.wrapped = 1'b0;
                    end
                end
                ST_ARMED, ST_POST: begin
                    if (s_q.st == ST_ARMED && !trig_i) begin
                        we_d = keep_i && (pos_i != POS_START);
                    end else begin
                        left_d = (s_q.st == ST_ARMED) ? load_d : s_q.cnt;
                        if (left_d == '0) begin
                            s_d.st = ST_FROZEN;
                        end else begin
                            we_d    = keep_i;
                            rem_d   = left_d - CW'(keep_i);
                            s_d.cnt = rem_d;
                            s_d.st  = (rem_d == '0) ? ST_FROZEN : ST_POST;
                        end
                    end
                end
                default: ;
            endcase
            if (we_d) begin
                s_d.ptr = s_q.ptr + 1'b1;
                if (s_q.ptr == LAST_SLOT) begin
                    s_d.wrapped = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ptr: '0, wrapped: 1'b0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        we_o      = we_d;
        ptr_o     = s_q.ptr;
        wrapped_o = s_q.wrapped;
        frozen_o  = (s_q.st == ST_FROZEN);
    end

    // R1: idle never writes
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |-> !we_o);
    // R2: each write moves the pointer by exactly one slot
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !rearm_i) |=> (ptr_o == PW'($past(ptr_o) + 1'b1)));
    // R4: wrap flag is sticky until re-arm
    p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped_o && !rearm_i) |=> wrapped_o);
    // R7: end position freezes on the trigger edge
    p_end_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ARMED && trig_i && pos_i[1] && !rearm_i) |=> frozen_o);
    // R8: a frozen buffer holds still
    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !rearm_i) |=> (frozen_o && $stable(ptr_o) && $stable(wrapped_o)));
    // R9: re-arm clears and arms
    p_rearm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (ptr_o == '0 && !wrapped_o && !frozen_o && s_q.st == ST_ARMED));
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int TW    = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int RW   = TW + DW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_valid,
    input  logic [AW-1:0] rec_addr,
    input  logic [DW-1:0] rec_data,
    input  logic [TW-1:0] rec_type,
    input  logic          trig,
    input  logic          run_start,
    input  logic          rearm,
    input  logic          win_en,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic [1:0]    trig_pos,
    input  logic [PW-1:0] rd_addr,
    output logic [RW-1:0] rd_data,
    output logic          frozen,
    output logic [PW-1:0] wr_ptr,
    output logic          wrapped
);
    logic keep;
    logic we;

    tcb_window #(.AW(AW)) u_window (
        .valid_i  (rec_valid),
        .win_en_i (win_en),
        .lo_i     (win_lo),
        .hi_i     (win_hi),
        .addr_i   (rec_addr),
        .keep_o   (keep)
    );

    tcb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .keep_i      (keep),
        .trig_i      (trig),
        .run_start_i (run_start),
        .rearm_i     (rearm),
        .pos_i       (trig_pos),
        .we_o        (we),
        .ptr_o       (wr_ptr),
        .wrapped_o   (wrapped),
        .frozen_o    (frozen)
    );

    tcb_store #(.DEPTH(DEPTH), .RW(RW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (wr_ptr),
        .wdata_i ({rec_type, rec_data, rec_addr}),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );
endmodule

// File: tb/sim_trace_capture_ctrl.sv
`timescale 1ns/1ps
module sim_trace_capture_ctrl;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic [15:0] rec_addr = '0;
    logic [15:0] rec_data = '0;
    logic [3:0]  rec_type = '0;
    logic        trig = 1'b0, run_start = 1'b0, rearm = 1'b0, win_en = 1'b0;
    logic [15:0] win_lo = '0, win_hi = '0;
    logic [1:0]  trig_pos = 2'd2;
    logic [3:0]  rd_addr = '0;
    logic [35:0] rd_data;
    logic        frozen, wrapped;
    logic [3:0]  wr_ptr;

    trace_capture_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_data(rec_data), .rec_type(rec_type), .trig(trig), .run_start(run_start),
        .rearm(rearm), .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi),
        .trig_pos(trig_pos), .rd_addr(rd_addr), .rd_data(rd_data),
        .frozen(frozen), .wr_ptr(wr_ptr), .wrapped(wrapped)
    );

    always #2 clk = ~clk;

    int          n_chk = 0, n_bad = 0, cyc = 0;
    string       tag = "R1";
    int          m_st = 0, m_ptr = 0, m_cnt = 0;
    bit          m_wrap = 0;
    logic [35:0] m_mem [D];

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic bit m_keep();
        return rec_valid && (!win_en || (rec_addr >= win_lo && rec_addr <= win_hi));
    endfunction

    task automatic m_write();
        m_mem[m_ptr] = {rec_type, rec_data, rec_addr};
        m_ptr = m_ptr + 1;
        if (m_ptr == D) begin m_ptr = 0; m_wrap = 1; end
    endtask

    // behavioural model, stepped once per clock
    task automatic m_step();
        int eff;
        bit k;
        k = m_keep();
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_wrap = 0; m_cnt = 0;
        end else if (rearm) begin
            m_st = 1; m_ptr = 0; m_wrap = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            if (run_start) begin m_st = 1; m_ptr = 0; m_wrap = 0; end
        end else if (m_st == 1 && !trig) begin
            if (k && trig_pos != 2'd0) m_write();
        end else if (m_st == 1 || m_st == 2) begin
            if (m_st == 1) eff = (trig_pos == 2'd0) ? D : (trig_pos == 2'd1) ? D / 2 : 0;
            else eff = m_cnt;
            if (eff == 0) m_st = 3;
            else begin
                if (k) begin m_write(); eff--; end
                m_cnt = eff;
                m_st = (eff == 0) ? 3 : 2;
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        m_step();
        @(negedge clk);
        chk(frozen == (m_st == 3), tag, "frozen", frozen, m_st == 3);
        chk(wr_ptr == m_ptr[3:0], tag, "wr_ptr", wr_ptr, m_ptr);
        chk(wrapped == m_wrap, tag, "wrapped", wrapped, m_wrap);
    endtask

    task automatic readback();
        int n;
        n = m_wrap ? D : m_ptr;
        for (int i = 0; i < n; i++) begin
            rd_addr = 4'(i);
            #0.1;
            chk(rd_data == m_mem[i], "R11", "rd_data", rd_data, m_mem[i]);
        end
    endtask

    task automatic rec(bit v, logic [15:0] a, bit t);
        rec_valid = v; rec_addr = a; rec_data = a ^ 16'h5A5A; rec_type = a[3:0];
        trig = t;
        cycle();
        trig = 1'b0;
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1; rec_valid = 1'b1; rec_addr = 16'h0105;
        cycle();
        rearm = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!frozen && wr_ptr == 0 && !wrapped, "R1", "reset state",
            {frozen, wrapped, wr_ptr}, 0);
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 5; i++) rec(1, 16'(i), i == 2);

        // all-trace, end position, wraps the ring
        tag = "R10"; run_start = 1'b1; rec(1, 16'h0AAA, 0); run_start = 1'b0;
        tag = "R2"; for (int i = 0; i < 10; i++) rec(i != 4, 16'(16'h1000 + i), 0);
        tag = "R10"; run_start = 1'b1; rec(1, 16'h1100, 0); run_start = 1'b0;
        tag = "R4"; for (int i = 0; i < 12; i++) rec(1, 16'(16'h2000 + i), 0);
        readback();
        tag = "R7"; rec(1, 16'h3000, 1);
        tag = "R8"; for (int i = 0; i < 6; i++) rec(1, 16'(16'h3100 + i), i % 2 == 0);
        readback();

        // windowed, middle position
        tag = "R9"; win_en = 1; win_lo = 16'h0100; win_hi = 16'h010F; trig_pos = 2'd1;
        pulse_rearm();
        tag = "R3";
        for (int i = 0; i < 24; i++) rec(1, 16'(16'h00F8 + i), 0);
        tag = "R6"; rec(1, 16'h0107, 1);
        for (int i = 0; i < 40; i++) rec(i % 3 != 0, 16'(16'h00FC + (i % 24)), i == 5);
        readback();

        // unfiltered, start position
        tag = "R5"; win_en = 0; trig_pos = 2'd0; pulse_rearm();
        for (int i = 0; i < 6; i++) rec(1, 16'(16'h4000 + i), 0);
        rec(0, 16'h4100, 1);
        for (int i = 0; i < 24; i++) rec(i % 4 != 1, 16'(16'h4200 + i), i == 3);
        readback();

        // inverted window, end position
        tag = "R3"; win_en = 1; win_lo = 16'h0200; win_hi = 16'h01FF; trig_pos = 2'd3;
        pulse_rearm();
        for (int i = 0; i < 8; i++) rec(1, 16'(16'h01F8 + 2 * i), 0);
        tag = "R7"; rec(1, 16'h01FF, 1);
        tag = "R9"; trig_pos = 2'd1; win_en = 0; pulse_rearm();
        rearm = 1'b1; trig = 1'b1; rec_valid = 1; cycle(); rearm = 1'b0; trig = 1'b0;

        // random mix
        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            rec_valid = ($urandom % 4) != 0;
            rec_addr  = 16'(16'h0100 + $urandom % 32);
            rec_data  = 16'($urandom);
            rec_type  = 4'($urandom);
            trig      = ($urandom % 16) == 0;
            rearm     = ($urandom % 64) == 0;
            run_start = ($urandom % 32) == 0;
            if (rearm) begin
                trig_pos = 2'($urandom);
                win_en   = 1'($urandom);
                win_lo   = 16'(16'h0100 + $urandom % 32);
                win_hi   = 16'(16'h0100 + $urandom % 32);
            end
            cycle();
            if (i % 50 == 0) readback();
        end
        rearm = 0; trig = 0; run_start = 0;
        readback();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule